// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page-table information for a 32-bit virtual address space built from 4 KB pages. A lookup presents a 20-bit virtual page number and a 12-bit page offset. One cycle later the block answers with hit or miss. On a hit it returns the cached 32-bit page entry and a physical address formed from the entry's upper 20 bits followed by the untouched offset. A miss raises a request line that tells an external page walker to fetch the missing information.

The storage has 16 sets of 4 ways. Every way holds a valid bit, a kind flag, a 16-bit tag and the cached 32-bit entry. The kind flag is 1 for a directory-level entry and 0 for a leaf entry, so both kinds share the same sets. A leaf lookup uses the full page number as its key. A directory lookup uses only the top 10 bits of the page number, zero-extended to 20 bits. Because the kind flag also takes part in the match, the two kinds can never satisfy each other's lookups.

The walker installs results through a refill port that names the set, tag, kind and entry. The refill first checks for an entry with the same key; if it finds one, it overwrites that way. Otherwise it allocates a way: the lowest-numbered invalid way if there is one, and otherwise the way chosen by a per-set round-robin pointer. Two flush inputs are available. One invalidates everything. The other is meant for a context switch and keeps every entry whose global bit (entry bit 8) is set.

Top module: `xtlb`

## Requirements
- R1: When `lk_req` is high in a cycle, `rsp_valid` is high in the next cycle. When `lk_req` is low, `rsp_valid` is low in the next cycle.
- R2: A leaf lookup (`lk_dir`=0) uses set index vpn[3:0] and tag vpn[19:4]. On a hit, `rsp_pte` is the cached entry and `rsp_paddr` = {entry[31:12], offset}. The low 12 bits of `rsp_paddr` always equal the offset given with the request.
- R3: A hit requires a way in the indexed set that is valid, has the same tag and has the same kind flag. An entry of the other kind with an identical set and tag does not hit.
- R4: A directory lookup (`lk_dir`=1) uses the key {10'b0, vpn[19:10]}. Its set is key[3:0] and its tag is key[19:4]. Any two page numbers with the same upper 10 bits therefore reach the same directory entry.
- R5: On a miss, `walk_req` is high together with `rsp_valid`, `rsp_hit` is low, and `rsp_pte` and `rsp_paddr[31:12]` are zero.
- R6: A refill that finds no matching entry writes the lowest-numbered invalid way of its set, if the set has one.
- R7: Each set has its own 2-bit round-robin pointer, which is zero after reset. The pointer advances by one on every refill that allocates a way in that set. When all ways are valid, the way under the pointer is replaced.
- R8: A refill whose set, tag and kind match a valid way overwrites that way in place and leaves the pointer unchanged. A set never holds two valid ways with the same tag and kind.
- R9: `flush_all` invalidates every way.
- R10: `flush_ng` invalidates every way whose entry bit 8 is 0 and keeps every way whose entry bit 8 is 1.
- R11: After reset, every way is invalid and `rsp_valid`, `rsp_hit` and `walk_req` are low.
- R12: A lookup issued in the same cycle as a refill sees the contents from before that refill. A refill issued in the same cycle as a flush is applied after the flush, so the new entry survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_dir | input | 1 | Lookup kind: 1 directory, 0 leaf |
| lk_vpn | input | 20 | Virtual page number |
| lk_off | input | 12 | Page offset |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | Response is a hit |
| walk_req | output | 1 | Response is a miss; walker must fetch |
| rsp_pte | output | 32 | Cached entry on hit, zero on miss |
| rsp_paddr | output | 32 | Frame bits joined with the offset |
| fill_en | input | 1 | Refill strobe |
| fill_dir | input | 1 | Refill kind: 1 directory, 0 leaf |
| fill_set | input | 4 | Refill set index |
| fill_tag | input | 16 | Refill tag |
| fill_pte | input | 32 | Refill entry contents |
| flush_all | input | 1 | Invalidate every way |
| flush_ng | input | 1 | Invalidate non-global ways |

## Verification
Some behaviours are checked by assertions on every cycle. These cover the one-cycle response timing, the offset passing through unchanged, zero frame bits on a miss, the absence of duplicate keys within any set, and an empty table (or one holding only global ways) after a flush. Other behaviours only the bench's scenarios can show. These include the index and tag split for each lookup kind, leaf and directory entries sharing one key without aliasing, invalid-first allocation followed by round-robin eviction, refill in place without moving the pointer, and the ordering of same-cycle lookup, refill and flush.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
    typedef enum logic {
        KIND_LEAF = 1'b0,
        KIND_DIR  = 1'b1
    } kind_e;

    localparam int DEF_VPN_W   = 20;
    localparam int DEF_OFF_W   = 12;
    localparam int DEF_PTE_W   = 32;
    localparam int DEF_NSETS   = 16;
    localparam int DEF_NWAYS   = 4;
    localparam int DEF_DIR_W   = 10;
    localparam int DEF_GLB_BIT = 8;
endpackage

// File: rtl/xtlb_match.sv
module xtlb_match #(
    parameter int NWAYS = 4,
    parameter int TAG_W = 16,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic [NWAYS-1:0]            way_vld,
    input  logic [NWAYS-1:0]            way_dir,
    input  logic [NWAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]            key_tag,
    input  logic                        key_dir,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [NWAYS-1:0] hit_vec;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] && (way_dir[w] == key_dir) && (way_tag[w] == key_tag);
    end

    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/xtlb_victim.sv
module xtlb_victim #(
    parameter int NWAYS = 4,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic [NWAYS-1:0] way_vld,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        victim = rr_ptr;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!way_vld[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/xtlb.sv
module xtlb
    import xtlb_pkg::*;
#(
    parameter int VPN_W   = DEF_VPN_W,
    parameter int OFF_W   = DEF_OFF_W,
    parameter int PTE_W   = DEF_PTE_W,
    parameter int NSETS   = DEF_NSETS,
    parameter int NWAYS   = DEF_NWAYS,
    parameter int DIR_W   = DEF_DIR_W,
    parameter int GLB_BIT = DEF_GLB_BIT,
    localparam int SET_W  = $clog2(NSETS),
    localparam int WAY_W  = $clog2(NWAYS),
    localparam int TAG_W  = VPN_W - SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic             lk_dir,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             walk_req,
    output logic [PTE_W-1:0] rsp_pte,
    output logic [PTE_W-1:0] rsp_paddr,
    input  logic             fill_en,
    input  logic             fill_dir,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             flush_all,
    input  logic             flush_ng
);
    localparam int NENT = NSETS * NWAYS;

    typedef struct packed {
        logic             vld;
        logic             dir;
        logic [TAG_W-1:0] tag;
        logic [PTE_W-1:0] pte;
    } ent_t;

    typedef struct packed {
        ent_t [NSETS-1:0][NWAYS-1:0] tbl;
        logic [NSETS-1:0][WAY_W-1:0] ptr;
        logic                        rv;
        logic                        hit;
        logic [PTE_W-1:0]            pte;
        logic [OFF_W-1:0]            off;
    } st_t;

    st_t st_d, st_q;

    // lookup key formation
    kind_e            lk_kind;
    logic [VPN_W-1:0] lk_key;
    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;

    always_comb begin
        lk_kind = kind_e'(lk_dir);
        if (lk_kind == KIND_DIR) lk_key = {{(VPN_W-DIR_W){1'b0}}, lk_vpn[VPN_W-1:VPN_W-DIR_W]};
        else                     lk_key = lk_vpn;
        lk_set = lk_key[SET_W-1:0];
        lk_tag = lk_key[VPN_W-1:SET_W];
    end

    // per-set views for the lookup set and the refill set
    logic [NWAYS-1:0]            lk_vld, lk_dirv, fl_vld, fl_dirv;
    logic [NWAYS-1:0][TAG_W-1:0] lk_tags, fl_tags;

    always_comb begin
        for (int w = 0; w < NWAYS; w++) begin
            lk_vld[w]  = st_q.tbl[lk_set][w].vld;
            lk_dirv[w] = st_q.tbl[lk_set][w].dir;
            lk_tags[w] = st_q.tbl[lk_set][w].tag;
            fl_vld[w]  = st_q.tbl[fill_set][w].vld;
            fl_dirv[w] = st_q.tbl[fill_set][w].dir;
            fl_tags[w] = st_q.tbl[fill_set][w].tag;
        end
    end

    logic             lk_hit, fm_hit;
    logic [WAY_W-1:0] lk_way, fm_way, vic_way;

    xtlb_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) u_lk_match (
        .way_vld (lk_vld),
        .way_dir (lk_dirv),
        .way_tag (lk_tags),
        .key_tag (lk_tag),
        .key_dir (lk_dir),
        .hit     (lk_hit),
        .hit_way (lk_way)
    );

    xtlb_match #(.NWAYS(NWAYS), .TAG_W(TAG_W)) u_fill_match (
        .way_vld (fl_vld),
        .way_dir (fl_dirv),
        .way_tag (fl_tags),
        .key_tag (fill_tag),
        .key_dir (fill_dir),
        .hit     (fm_hit),
        .hit_way (fm_way)
    );

    xtlb_victim #(.NWAYS(NWAYS)) u_victim (
        .way_vld (fl_vld),
        .rr_ptr  (st_q.ptr[fill_set]),
        .victim  (vic_way)
    );

    // next-state logic
    ent_t new_ent;

    always_comb begin
        st_d = st_q;
        new_ent = '{vld: 1'b1, dir: fill_dir, tag: fill_tag, pte: fill_pte};

        st_d.rv  = lk_req;
        st_d.hit = lk_req && lk_hit;
        st_d.off = lk_off;
        st_d.pte = (lk_req && lk_hit) ? st_q.tbl[lk_set][lk_way].pte : '0;

        for (int s = 0; s < NSETS; s++) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (flush_all || (flush_ng && !st_q.tbl[s][w].pte[GLB_BIT])) begin
                    st_d.tbl[s][w].vld = 1'b0;
                end
            end
        end

        if (fill_en) begin
            if (fm_hit) begin
                st_d.tbl[fill_set][fm_way] = new_ent;
            end else begin
                st_d.tbl[fill_set][vic_way] = new_ent;
                st_d.ptr[fill_set] = st_q.ptr[fill_set] + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.rv && st_q.hit;
    assign walk_req  = st_q.rv && !st_q.hit;
    assign rsp_pte   = st_q.pte;
    assign rsp_paddr = {st_q.pte[PTE_W-1:OFF_W], st_q.off};

    // ---------------- assertions ----------------
    logic [NENT-1:0]  all_vld, ng_vld;
    logic [NSETS-1:0] set_dup;

    always_comb begin
        for (int s = 0; s < NSETS; s++) begin
            for (int w = 0; w < NWAYS; w++) begin
                all_vld[s*NWAYS+w] = st_q.tbl[s][w].vld;
                ng_vld[s*NWAYS+w]  = st_q.tbl[s][w].vld && !st_q.tbl[s][w].pte[GLB_BIT];
            end
        end
    end

    for (genvar s = 0; s < NSETS; s++) begin : g_dup
        always_comb begin
            set_dup[s] = 1'b0;
            for (int i = 0; i < NWAYS; i++) begin
                for (int j = i + 1; j < NWAYS; j++) begin
                    if (st_q.tbl[s][i].vld && st_q.tbl[s][j].vld &&
                        st_q.tbl[s][i].dir == st_q.tbl[s][j].dir &&
                        st_q.tbl[s][i].tag == st_q.tbl[s][j].tag) set_dup[s] = 1'b1;
                end
            end
        end

        AST_NO_DUP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
            !set_dup[s]); // R8
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid); // R1
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid); // R1
    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_paddr[OFF_W-1:0] == $past(lk_off)); // R2
    AST_MISS_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (rsp_paddr[PTE_W-1:OFF_W] == '0 && !rsp_hit)); // R5
    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !fill_en) |=> $countones(all_vld) == 0); // R9
    AST_FLUSH_NG_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ng && !fill_en) |=> $countones(ng_vld) == 0); // R10
endmodule

// File: tb/xtlb_test.sv
module xtlb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_dir = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [11:0] lk_off = '0;
    logic        rsp_valid, rsp_hit, walk_req;
    logic [31:0] rsp_pte, rsp_paddr;
    logic        fill_en = 1'b0, fill_dir = 1'b0;
    logic [3:0]  fill_set = '0;
    logic [15:0] fill_tag = '0;
    logic [31:0] fill_pte = '0;
    logic        flush_all = 1'b0, flush_ng = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xtlb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_dir(lk_dir), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .walk_req(walk_req),
        .rsp_pte(rsp_pte), .rsp_paddr(rsp_paddr),
        .fill_en(fill_en), .fill_dir(fill_dir), .fill_set(fill_set),
        .fill_tag(fill_tag), .fill_pte(fill_pte),
        .flush_all(flush_all), .flush_ng(flush_ng)
    );

    localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_FALL = 2'd2, OP_FNG = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic        dir;
        logic [19:0] vpn;
        logic [11:0] off;
        logic [31:0] pte;
        logic        hit;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{OP_LOOK, 1'b0, 20'h12345, 12'hABC, 32'h0,        1'b0}, // R5 cold miss
        '{OP_FILL, 1'b0, 20'h12345, 12'h000, 32'hAAAAA007, 1'b0},
        '{OP_LOOK, 1'b0, 20'h12345, 12'h123, 32'hAAAAA007, 1'b1}, // R2
        '{OP_LOOK, 1'b1, 20'h12345, 12'h456, 32'h0,        1'b0}, // R3 leaf does not serve dir
        '{OP_FILL, 1'b1, 20'h12345, 12'h000, 32'h55555103, 1'b0},
        '{OP_LOOK, 1'b1, 20'h12000, 12'h010, 32'h55555103, 1'b1}, // R4 shared upper bits
        '{OP_FILL, 1'b0, 20'h00048, 12'h000, 32'h77777001, 1'b0}, // same set/tag as dir entry
        '{OP_LOOK, 1'b0, 20'h00048, 12'hFFF, 32'h77777001, 1'b1}, // R3
        '{OP_LOOK, 1'b1, 20'h12345, 12'h001, 32'h55555103, 1'b1}, // R3
        '{OP_LOOK, 1'b0, 20'h12346, 12'h002, 32'h0,        1'b0}, // R5
        '{OP_FILL, 1'b0, 20'h12345, 12'h000, 32'hBBBBB005, 1'b0}, // R8 in place
        '{OP_LOOK, 1'b0, 20'h12345, 12'h777, 32'hBBBBB005, 1'b1}, // R8
        '{OP_FNG,  1'b0, 20'h0,     12'h000, 32'h0,        1'b0},
        '{OP_LOOK, 1'b0, 20'h12345, 12'h003, 32'h0,        1'b0}, // R10
        '{OP_LOOK, 1'b1, 20'h12345, 12'h004, 32'h55555103, 1'b1}, // R10 global kept
        '{OP_LOOK, 1'b0, 20'h00048, 12'h005, 32'h0,        1'b0}, // R10
        '{OP_FALL, 1'b0, 20'h0,     12'h000, 32'h0,        1'b0},
        '{OP_LOOK, 1'b1, 20'h12345, 12'h006, 32'h0,        1'b0}  // R9
    };

    function automatic logic [19:0] key_of(input logic [19:0] vpn, input logic dir);
        return dir ? {10'b0, vpn[19:10]} : vpn;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic dir, input logic [31:0] pte);
        logic [19:0] k;
        k = key_of(vpn, dir);
        fill_en  = 1'b1;
        fill_dir = dir;
        fill_set = k[3:0];
        fill_tag = k[19:4];
        fill_pte = pte;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic dir, input logic [31:0] pte);
        set_fill(vpn, dir, pte);
        tick();
        fill_en = 1'b0;
    endtask

    task automatic do_flush(input logic all);
        flush_all = all;
        flush_ng  = !all;
        tick();
        flush_all = 1'b0;
        flush_ng  = 1'b0;
    endtask

    task automatic do_look(input string req, input logic [19:0] vpn, input logic dir,
                           input logic [11:0] off, input logic exp_hit, input logic [31:0] exp_pte);
        logic [31:0] ep;
        lk_req = 1'b1;
        lk_dir = dir;
        lk_vpn = vpn;
        lk_off = off;
        tick();
        lk_req = 1'b0;
        ep = exp_hit ? exp_pte : 32'h0;
        check(req, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check(req, "rsp_hit",   {31'b0, rsp_hit},   {31'b0, exp_hit});
        check(req, "walk_req",  {31'b0, walk_req},  {31'b0, !exp_hit});
        check(req, "rsp_pte",   rsp_pte, ep);
        check(req, "rsp_paddr", rsp_paddr, {ep[31:12], off});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R11", "rsp_hit",   {31'b0, rsp_hit},   32'd0);
        check("R11", "walk_req",  {31'b0, walk_req},  32'd0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            case (VECS[i].op)
                OP_LOOK: do_look($sformatf("vec%0d", i), VECS[i].vpn, VECS[i].dir,
                                 VECS[i].off, VECS[i].hit, VECS[i].pte);
                OP_FILL: do_fill(VECS[i].vpn, VECS[i].dir, VECS[i].pte);
                OP_FALL: do_flush(1'b1);
                default: do_flush(1'b0);
            endcase
        end

        // R1: response drops when no request
        tick();
        check("R1", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);

        // R7 / R8: round robin and in-place refill in set 3
        do_flush(1'b1);
        do_fill(20'h00013, 1'b0, 32'h13000000);
        do_fill(20'h00023, 1'b0, 32'h23000000);
        do_fill(20'h00033, 1'b0, 32'h33000100); // global
        do_fill(20'h00043, 1'b0, 32'h43000000);
        do_fill(20'h00023, 1'b0, 32'h23F00000); // R8 in place, ptr stays 0
        do_fill(20'h00053, 1'b0, 32'h53000000); // R7 evicts way0
        do_fill(20'h00063, 1'b0, 32'h63000000); // R7 evicts way1
        do_look("R7", 20'h00013, 1'b0, 12'h011, 1'b0, 32'h0);
        do_look("R8", 20'h00023, 1'b0, 12'h022, 1'b0, 32'h0);
        do_look("R8", 20'h00033, 1'b0, 12'h033, 1'b1, 32'h33000100);
        do_look("R7", 20'h00043, 1'b0, 12'h044, 1'b1, 32'h43000000);
        do_look("R7", 20'h00063, 1'b0, 12'h066, 1'b1, 32'h63000000);

        // R6: invalid ways first, pointer now 2
        do_flush(1'b0); // only 0x00033 (way2) remains
        do_fill(20'h00073, 1'b0, 32'h73000000); // way0, ptr 3
        do_fill(20'h00083, 1'b0, 32'h83000000); // way1, ptr 0
        do_fill(20'h00093, 1'b0, 32'h93000000); // way3, ptr 1
        do_fill(20'h000A3, 1'b0, 32'hA3000000); // evicts way1
        do_look("R6", 20'h00033, 1'b0, 12'h100, 1'b1, 32'h33000100);
        do_look("R6", 20'h00073, 1'b0, 12'h101, 1'b1, 32'h73000000);
        do_look("R7", 20'h00083, 1'b0, 12'h102, 1'b0, 32'h0);
        do_look("R6", 20'h00093, 1'b0, 12'h103, 1'b1, 32'h93000000);
        do_look("R7", 20'h000A3, 1'b0, 12'h104, 1'b1, 32'hA3000000);

        // R12: lookup in the refill cycle sees old contents
        set_fill(20'h00105, 1'b0, 32'h10500000);
        lk_req = 1'b1; lk_dir = 1'b0; lk_vpn = 20'h00105; lk_off = 12'h0AA;
        tick();
        lk_req = 1'b0; fill_en = 1'b0;
        check("R12", "same-cycle rsp_hit", {31'b0, rsp_hit}, 32'd0);
        do_look("R12", 20'h00105, 1'b0, 12'h0AB, 1'b1, 32'h10500000);

        // R12: refill with flush survives
        set_fill(20'h00205, 1'b1, 32'h20500000);
        flush_all = 1'b1;
        tick();
        flush_all = 1'b0; fill_en = 1'b0;
        do_look("R12", 20'h00205, 1'b1, 12'h0CC, 1'b1, 32'h20500000);
        do_look("R9",  20'h00105, 1'b0, 12'h0CD, 1'b0, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule